// File: doc/BRIEF.md
# Banked RAM and ROM Address Decoder

This block is the memory front end of a small processor bus with a 10-bit byte address. It holds four 128-byte RAM banks and one 512-byte ROM. The top address bit splits the space into a RAM half and a ROM half. Inside the RAM half, the next two bits drive a 2-to-4 decoder that selects one bank.

Every chip is gated by a pair of chip selects. The first select is active high and the second is active low. Within an active RAM chip, the write strobe takes priority over the read strobe. The tri-state outputs of the chips are modelled as per-chip output enables. One multiplexed read-data bus returns the byte of whichever chip is enabled.

Timing is as follows. A write lands in a RAM bank on the rising clock edge. A read is registered on that same edge, so the data appears on the read bus after the edge and stays there until the next edge.

Top module: `bus_mem_front`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `chip_drive` is 0 and `bus_rdata` is 0x00, whatever the strobes and address are.
- R2: Address bit 9 = 0 selects RAM. Bits 8:7 pick the bank (0x000–0x07F bank 0, 0x080–0x0FF bank 1, 0x100–0x17F bank 2, 0x180–0x1FF bank 3). Bits 6:0 pick the byte. Every one of the 512 RAM bytes is separately storable.
- R3: On a RAM address with `bus_wr`=1, the byte `bus_wdata` is stored at the rising edge, whatever `bus_rd` is. In the following cycle no RAM output is enabled.
- R4: On a RAM address with `bus_wr`=0 and `bus_rd`=1, the following cycle has `chip_drive` = one-hot bit (bank number) and `bus_rdata` equal to the stored byte.
- R5: On a RAM address with both strobes 0, the chip is inhibited. The following cycle has `chip_drive`=0 and `bus_rdata`=0x00, and no stored byte changes.
- R6: Address bit 9 = 1 with `bus_rd`=1 enables the ROM, whatever `bus_wr` is. The following cycle has `chip_drive`=0x10 (bit 4). `bus_rdata` = low 8 bits of (3·offset + ROM_SEED), with all 8 bits inverted when offset bit 8 is 1. The offset is address bits 8:0, and ROM_SEED defaults to 0x5A.
- R7: A write to the ROM half changes neither the ROM data nor any RAM byte, even though its low 9 address bits equal those of a RAM byte.
- R8: At most one bit of `chip_drive` is set in any cycle.
- R9: When no bit of `chip_drive` is set, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Byte address; bit 9 picks RAM half or ROM half |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wdata | input | 8 | Byte to store on a write |
| bus_rdata | output | 8 | Byte from the enabled chip, 0x00 when none drives |
| chip_drive | output | 5 | Output enables: bits 3:0 RAM banks 0–3, bit 4 ROM |

## Verification
The hardest case to reach is a ROM-half write whose low nine address bits are identical to those of a RAM byte already holding known data. Only a decoder that lets the region bit leak through would corrupt that RAM byte. The stimulus first fills all 512 RAM bytes with an address-derived pattern. It then writes inverted data to every ROM address and reads the whole RAM and the whole ROM back, so any aliasing shows up as a mismatch. Writes are also issued with the read strobe high on alternate addresses, which exercises the write-priority row of the function table.

// File: rtl/memsel_pkg.sv
// Package: shared geometry, chip-function encoding and ROM content rule
// for the banked RAM/ROM bus front end.
// Assumes a byte-wide bus and a RAM half made of equal power-of-two banks.
package memsel_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 8;
    localparam int RAM_AW  = 7;
    localparam int N_RAM   = 4;
    localparam int BANK_W  = $clog2(N_RAM);
    localparam int ROM_AW  = ADDR_W - 1;
    localparam int N_CHIP  = N_RAM + 1;
    localparam int ROM_IDX = N_RAM;
    localparam int SUM_W   = 2 * DATA_W + ROM_AW;

    // Operation a chip performs for a given select/strobe combination
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } chip_op_e;

    // Registered bus request used for the read path
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              rd;
    } bus_req_t;

    // Two-select function table: active needs cs1 high and cs2 low;
    // the write strobe wins over the read strobe.
    function automatic chip_op_e chip_op(input logic cs1, input logic cs2,
                                         input logic wr, input logic rd);
        if (!cs1 || cs2) return OP_IDLE;
        if (wr)          return OP_WRITE;
        if (rd)          return OP_READ;
        return OP_IDLE;
    endfunction

    // ROM content: low byte of 3*offset + seed, inverted in the upper half
    function automatic logic [DATA_W-1:0] rom_word(input logic [ROM_AW-1:0] a,
                                                   input logic [DATA_W-1:0] seed);
        logic [SUM_W-1:0] t;
        t = SUM_W'(a) * SUM_W'(3) + SUM_W'(seed);
        return t[DATA_W-1:0] ^ {DATA_W{a[ROM_AW-1]}};
    endfunction

endpackage

// File: rtl/memsel_decode.sv
// Module: address decoder for the RAM half.
// Produces the first select of every RAM bank from the bank field and the
// shared second select from the region bit. The decoder is not gated by
// the region; the second select does that, per the chip function table.
module memsel_decode
    import memsel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [N_RAM-1:0]  ram_cs1,
    output logic              ram_cs2
);

    logic [BANK_W-1:0] bank_field;

    // Extract the bank field and the region bit
    always_comb begin
        bank_field = addr[ADDR_W-2 -: BANK_W];
        ram_cs2    = addr[ADDR_W-1];
    end

    // One decoder output per bank
    for (genvar k = 0; k < N_RAM; k++) begin : g_dec
        assign ram_cs1[k] = (bank_field == BANK_W'(k));
    end

endmodule

// File: rtl/memsel_ram_bank.sv
// Module: one RAM bank with two-select gating.
// The write port takes the live bus and stores on the rising edge; the read
// port takes the registered request and returns data combinationally with
// an output enable that stands in for the tri-state driver.
// Assumes storage needs no reset.
module memsel_ram_bank
    import memsel_pkg::*;
#(
    parameter int AW = RAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          w_cs1,
    input  logic          w_cs2,
    input  logic          w_wr,
    input  logic          w_rd,
    input  logic [AW-1:0] w_addr,
    input  logic [DW-1:0] w_data,
    input  logic          r_cs1,
    input  logic          r_cs2,
    input  logic          r_wr,
    input  logic          r_rd,
    input  logic [AW-1:0] r_addr,
    output logic [DW-1:0] r_data,
    output logic          r_oe
);

    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] store [DEPTH];
    chip_op_e      w_op;
    chip_op_e      r_op;

    // Apply the function table to both the live and the registered strobes
    always_comb begin
        w_op = chip_op(w_cs1, w_cs2, w_wr, w_rd);
        r_op = chip_op(r_cs1, r_cs2, r_wr, r_rd);
    end

    // Store the input byte when the live request is a write to this bank
    always_ff @(posedge clk) begin
        if (w_op == OP_WRITE) store[w_addr] <= w_data;
    end

    // Drive the output only for a registered read of this bank
    always_comb begin
        r_oe   = (r_op == OP_READ);
        r_data = r_oe ? store[r_addr] : '0;
    end

endmodule

// File: rtl/memsel_rom.sv
// Module: read-only store with two-select gating.
// The first select is the read strobe (output enable), the second is the
// inverted region bit. Contents follow the package content rule and cannot
// be written.
module memsel_rom
    import memsel_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 8'h5A
) (
    input  logic              cs1,
    input  logic              cs2,
    input  logic [ROM_AW-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              oe
);

    // Enable when cs1 high and cs2 low, then look up the computed content
    always_comb begin
        oe   = cs1 && !cs2;
        data = oe ? rom_word(addr, SEED) : '0;
    end

endmodule

// File: rtl/memsel_rdmux.sv
// Module: read-data combiner.
// ORs each chip's byte gated by its output enable; yields zero when no
// chip is enabled. Assumes at most one enable is set at a time.
module memsel_rdmux
    import memsel_pkg::*;
#(
    parameter int NC = N_CHIP,
    parameter int DW = DATA_W
) (
    input  logic [NC-1:0]    oe,
    input  logic [NC*DW-1:0] words,
    output logic [DW-1:0]    data
);

    // Gate and merge every chip word into the shared bus
    always_comb begin
        data = '0;
        for (int i = 0; i < NC; i++) begin
            if (oe[i]) data = data | words[i*DW +: DW];
        end
    end

endmodule

// File: rtl/bus_mem_front.sv
// Module: top of the banked RAM/ROM bus front end.
// Registers the read request, decodes live and registered addresses into
// chip selects, holds four RAM banks and one ROM, and merges their outputs.
// Assumes synchronous active-low reset; only the request register is reset.
module bus_mem_front
    import memsel_pkg::*;
#(
    parameter logic [DATA_W-1:0] ROM_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CHIP-1:0] chip_drive
);

    bus_req_t                req_q;
    logic [N_RAM-1:0]        w_cs1;
    logic                    w_cs2;
    logic [N_RAM-1:0]        r_cs1;
    logic                    r_cs2;
    logic [N_CHIP*DATA_W-1:0] chip_words;
    logic [N_CHIP-1:0]       chip_oe;

    // Capture the bus request for the read path; reset clears the strobes
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= '{addr: bus_addr, wr: bus_wr, rd: bus_rd};
    end

    memsel_decode u_dec_live (
        .addr    (bus_addr),
        .ram_cs1 (w_cs1),
        .ram_cs2 (w_cs2)
    );

    memsel_decode u_dec_reg (
        .addr    (req_q.addr),
        .ram_cs1 (r_cs1),
        .ram_cs2 (r_cs2)
    );

    for (genvar k = 0; k < N_RAM; k++) begin : g_bank
        memsel_ram_bank #(
            .AW (RAM_AW),
            .DW (DATA_W)
        ) u_bank (
            .clk    (clk),
            .w_cs1  (w_cs1[k]),
            .w_cs2  (w_cs2),
            .w_wr   (bus_wr),
            .w_rd   (bus_rd),
            .w_addr (bus_addr[RAM_AW-1:0]),
            .w_data (bus_wdata),
            .r_cs1  (r_cs1[k]),
            .r_cs2  (r_cs2),
            .r_wr   (req_q.wr),
            .r_rd   (req_q.rd),
            .r_addr (req_q.addr[RAM_AW-1:0]),
            .r_data (chip_words[k*DATA_W +: DATA_W]),
            .r_oe   (chip_oe[k])
        );
    end

    memsel_rom #(
        .SEED (ROM_SEED)
    ) u_rom (
        .cs1  (req_q.rd),
        .cs2  (!req_q.addr[ADDR_W-1]),
        .addr (req_q.addr[ROM_AW-1:0]),
        .data (chip_words[ROM_IDX*DATA_W +: DATA_W]),
        .oe   (chip_oe[ROM_IDX])
    );

    memsel_rdmux #(
        .NC (N_CHIP),
        .DW (DATA_W)
    ) u_mux (
        .oe    (chip_oe),
        .words (chip_words),
        .data  (bus_rdata)
    );

    // Expose the per-chip enables
    always_comb chip_drive = chip_oe;

endmodule

// File: rtl/bus_mem_front_chk.sv
// Module: property checker for bus_mem_front, attached by bind.
// Keeps a one-cycle "request valid" flag so that no property looks at a
// request sampled while reset was applied.
module bus_mem_front_chk
    import memsel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_CHIP-1:0] chip_drive
);

    logic live_q;

    // Mark cycles whose previous edge was outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> chip_drive == '0);

    a_r3_write_mutes_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(bus_wr) && !$past(bus_addr[ADDR_W-1])) |-> chip_drive == '0);

    a_r4_ram_read_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(bus_wr) && $past(bus_rd) && !$past(bus_addr[ADDR_W-1]))
        |-> chip_drive == (N_CHIP'(1) << $past(bus_addr[ADDR_W-2 -: BANK_W])));

    a_r5_inhibit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(bus_wr) && !$past(bus_rd)) |-> chip_drive == '0);

    a_r6_rom_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(bus_rd) && $past(bus_addr[ADDR_W-1]))
        |-> chip_drive == (N_CHIP'(1) << ROM_IDX));

    a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_drive));

    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_drive == '0) |-> bus_rdata == '0);

endmodule

bind bus_mem_front bus_mem_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .chip_drive (chip_drive)
);

// File: tb/bus_mem_front_bench.sv
// Bench: exhaustive sweeps of RAM and ROM space with arithmetic expectations.
module bus_mem_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;
    localparam logic [7:0] SEED = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] chip_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_mem_front #(.ROM_SEED(SEED)) u_bus_mem_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .chip_drive (chip_drive)
    );

    // RAM fill pattern, differs between banks at equal offsets
    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + (a >> 7) * 29) & 8'hFF);
    endfunction

    // ROM content rule from R6
    function automatic logic [7:0] rom_exp(input int off);
        logic [7:0] v;
        v = 8'((off * 3 + int'(SEED)) & 8'hFF);
        if (off >= 256) v = ~v;
        return v;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return at the next falling edge
    task automatic cyc(input logic [9:0] a, input logic w, input logic r, input logic [7:0] d);
        bus_addr  = a;
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset with a ROM read request pending
        @(negedge clk);
        cyc(10'h200, 1'b0, 1'b1, 8'h00);
        cyc(10'h200, 1'b0, 1'b1, 8'h00);
        check("R1 drive in reset", 8'(chip_drive), 8'h00);
        check("R1 rdata in reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        cyc(10'h000, 1'b0, 1'b0, 8'h00);
        check("R1 drive after release", 8'(chip_drive), 8'h00);

        // R2/R3: fill all RAM, read strobe high on odd addresses
        for (int a = 0; a < 512; a++) begin
            cyc(10'(a), 1'b1, a[0], pat(a));
            check("R3 write mutes output", 8'(chip_drive), 8'h00);
            check("R9 rdata idle during write", bus_rdata, 8'h00);
        end

        // R2/R4: read every RAM byte
        for (int a = 0; a < 512; a++) begin
            cyc(10'(a), 1'b0, 1'b1, 8'hFF);
            check("R4 bank enable", 8'(chip_drive), 8'(1 << (a >> 7)));
            check("R2 stored byte", bus_rdata, pat(a));
        end

        // R5: inhibited accesses carry junk data but store nothing
        for (int a = 0; a < 512; a += 37) begin
            cyc(10'(a), 1'b0, 1'b0, ~pat(a));
            check("R5 inhibit drive", 8'(chip_drive), 8'h00);
            check("R5 inhibit rdata", bus_rdata, 8'h00);
            cyc(10'(a), 1'b0, 1'b1, 8'h00);
            check("R5 byte unchanged", bus_rdata, pat(a));
        end

        // R6: read the whole ROM
        for (int o = 0; o < 512; o++) begin
            cyc(10'(512 + o), 1'b0, 1'b1, 8'h00);
            check("R6 rom enable", 8'(chip_drive), 8'h10);
            check("R6 rom byte", bus_rdata, rom_exp(o));
            check("R8 single driver", 8'($countones(chip_drive)), 8'd1);
        end

        // R6: ROM drives with both strobes high
        cyc(10'h2C3, 1'b1, 1'b1, 8'h00);
        check("R6 rom with write strobe", bus_rdata, rom_exp(9'h0C3));

        // R7: write inverted data across the ROM half
        for (int o = 0; o < 512; o++) begin
            cyc(10'(512 + o), 1'b1, 1'b0, ~rom_exp(o));
            check("R7 rom write no drive", 8'(chip_drive), 8'h00);
        end
        for (int o = 0; o < 512; o++) begin
            cyc(10'(512 + o), 1'b0, 1'b1, 8'h00);
            check("R7 rom unchanged", bus_rdata, rom_exp(o));
        end
        for (int a = 0; a < 512; a++) begin
            cyc(10'(a), 1'b0, 1'b1, 8'h00);
            check("R7 ram not aliased", bus_rdata, pat(a));
        end

        // R9: idle bus reads zero
        cyc(10'h155, 1'b0, 1'b0, 8'hAA);
        check("R9 idle rdata", bus_rdata, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule